// File: doc/BRIEF.md
# I/O Transfer Pulse Sequencer with Skip

This block sets the timing of the input/output transfer instruction of a 12-bit minicomputer. When the instruction word carries opcode 6 and the processor is in the fetch major state, the TS3 strobe starts a pause of three clock cycles. The external time-state generator must wait for the pause to end before it issues TS4. Each pause cycle is one I/O pulse slot. A slot drives its pulse line only when the matching low-order bit of the instruction is set. A slot whose bit is clear still takes its cycle, so the pause length does not depend on the instruction word.

The first slot also acts as the skip strobe. While that pulse is high, the three device skip lines are ORed and the result is captured in a skip flip-flop. A set flip-flop produces a single carry-insert into the program-counter incrementer, and only inside one PC-enable window at TS4. The pulse sequence spans several cycles, but the skip still adds exactly one word to the PC, not one per slot. The flip-flop is cleared by reset and at TS1 of every fetch.

The block has no streaming data path. Every pin is a plain control or status level, or a single-cycle strobe, so no back-pressure applies.

Top module: `iot_sequencer`

## Requirements
- R1: After reset, `pause`, every `io_pulse` bit and `carry_insert` are low.
- R2: When `ts3` and `fetch` are high and `instr[11:9]` equals 6, `pause` rises on the next cycle and stays high for exactly 3 cycles, whatever the low instruction bits are.
- R3: `io_pulse[0]` (the first pulse) is high in the first pause cycle when `instr[0]` is set. `io_pulse[1]` (the second pulse) is high in the second pause cycle when `instr[1]` is set. `io_pulse[2]` (the fourth pulse) is high in the third pause cycle when `instr[2]` is set. Each pulse lasts one cycle, and at most one bit of `io_pulse` is high at a time.
- R4: No pause and no I/O pulse occur for any other opcode, or when `fetch` is low at TS3.
- R5: If any bit of `skip_req` is high while `io_pulse[0]` is high, the skip is taken. Bit 0 is power-fail, bit 1 is reader and bit 2 is teleprinter, and each bit alone is enough.
- R6: If `instr[0]` is clear, the instruction takes no skip, even when skip lines are high (for example octal 6046).
- R7: `carry_insert` is high only during TS4 with `fetch` high, and at most once per instruction. A taken skip therefore advances the PC by 2 in total, and an untaken one by 1.
- R8: A skip taken by one instruction does not carry into the next: TS1 of a fetch clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 12 | Instruction word; bits 11:9 hold the opcode |
| ts1 | input | 1 | Time state 1 strobe, one cycle |
| ts3 | input | 1 | Time state 3 strobe, one cycle |
| ts4 | input | 1 | Time state 4 strobe, one cycle |
| fetch | input | 1 | High in the fetch major state |
| skip_req | input | 3 | Device skip lines: 0 power-fail, 1 reader, 2 teleprinter |
| io_pulse | output | 3 | I/O pulses for the first, second and fourth slot |
| pause | output | 1 | High while the pulse slots run; the timing generator holds TS4 off |
| carry_insert | output | 1 | Extra carry into the PC incrementer at TS4 |

## Verification
The assertions assume that the time-state strobes are single-cycle pulses, issued in the order TS1, TS3, TS4 within each instruction. They also assume that TS4 never arrives while `pause` is high, and that `instr` and `fetch` stay steady from TS1 until TS4. The bench stays within these assumptions through one timing task. That task drives the strobes on falling edges in this order, waits for `pause` to fall before it raises TS4, and changes the instruction word only between instructions.

// File: rtl/iot_pkg.sv
package iot_pkg;
  localparam int OPC_W      = 3;
  localparam logic [OPC_W-1:0] OPC_IOT = 3'd6;
  localparam int SKIP_PWR   = 0;
  localparam int SKIP_RDR   = 1;
  localparam int SKIP_TTY   = 2;

  function automatic logic is_iot_op(input logic [OPC_W-1:0] opc);
    return opc == OPC_IOT;
  endfunction
endpackage

// File: rtl/iot_slot_seq.sv
module iot_slot_seq #(
  parameter int NUM_SLOTS = 3,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              pause,
  output logic [SLOT_W-1:0] slot,
  output logic              last_slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  assign last_slot = pause && (slot == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause <= 1'b0;
      slot  <= '0;
    end else if (start && !pause) begin
      pause <= 1'b1;
      slot  <= '0;
    end else if (pause) begin
      if (slot == LAST) begin
        pause <= 1'b0;
        slot  <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iot_pulse_gate.sv
module iot_pulse_gate #(
  parameter int NUM_SLOTS = 3,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 pause,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [NUM_SLOTS-1:0] sel_bits,
  output logic [NUM_SLOTS-1:0] io_pulse
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign io_pulse[k] = pause && (slot == SLOT_W'(k)) && sel_bits[k];
  end
endmodule

// File: rtl/iot_skip_ctl.sv
module iot_skip_ctl #(
  parameter int NUM_SKIP_SRC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ts1,
  input  logic                    ts4,
  input  logic                    fetch,
  input  logic                    is_iot,
  input  logic                    skip_strobe,
  input  logic [NUM_SKIP_SRC-1:0] skip_req,
  input  logic                    seq_end,
  output logic                    carry_insert
);
  logic skip_q;
  logic io_done_q;
  logic pc_en;
  logic io_pc_en;
  logic fetch_start;

  assign fetch_start = ts1 && fetch;

  always_ff @(posedge clk) begin
    if (!rst_n)                         skip_q <= 1'b0;
    else if (fetch_start)               skip_q <= 1'b0;
    else if (skip_strobe && |skip_req)  skip_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   io_done_q <= 1'b0;
    else if (fetch_start || ts4)  io_done_q <= 1'b0;
    else if (seq_end)             io_done_q <= 1'b1;
  end

  // ordinary window: TS4 of a fetch that did not run I/O slots
  assign pc_en    = ts4 && fetch && !is_iot;
  // I/O window: TS4 once the pulse slots have all elapsed
  assign io_pc_en = ts4 && fetch && io_done_q;

  assign carry_insert = skip_q && (pc_en || io_pc_en);
endmodule

// File: rtl/iot_sequencer.sv
module iot_sequencer
  import iot_pkg::*;
#(
  parameter int WORD_W       = 12,
  parameter int NUM_SLOTS    = 3,
  parameter int NUM_SKIP_SRC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_W-1:0]       instr,
  input  logic                    ts1,
  input  logic                    ts3,
  input  logic                    ts4,
  input  logic                    fetch,
  input  logic [NUM_SKIP_SRC-1:0] skip_req,
  output logic [NUM_SLOTS-1:0]    io_pulse,
  output logic                    pause,
  output logic                    carry_insert
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic              is_iot;
  logic              start;
  logic [SLOT_W-1:0] slot;
  logic              last_slot;

  assign is_iot = is_iot_op(instr[WORD_W-1 -: OPC_W]);
  assign start  = ts3 && fetch && is_iot;

  iot_slot_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pause    (pause),
    .slot     (slot),
    .last_slot(last_slot)
  );

  iot_pulse_gate #(.NUM_SLOTS(NUM_SLOTS)) u_gate (
    .pause   (pause),
    .slot    (slot),
    .sel_bits(instr[NUM_SLOTS-1:0]),
    .io_pulse(io_pulse)
  );

  iot_skip_ctl #(.NUM_SKIP_SRC(NUM_SKIP_SRC)) u_skip (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts1         (ts1),
    .ts4         (ts4),
    .fetch       (fetch),
    .is_iot      (is_iot),
    .skip_strobe (io_pulse[0]),
    .skip_req    (skip_req),
    .seq_end     (last_slot),
    .carry_insert(carry_insert)
  );
endmodule

// File: rtl/iot_sequencer_chk.sv
module iot_sequencer_chk
  import iot_pkg::*;
#(
  parameter int WORD_W       = 12,
  parameter int NUM_SLOTS    = 3,
  parameter int NUM_SKIP_SRC = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [WORD_W-1:0]       instr,
  input logic                    ts1,
  input logic                    ts3,
  input logic                    ts4,
  input logic                    fetch,
  input logic [NUM_SKIP_SRC-1:0] skip_req,
  input logic [NUM_SLOTS-1:0]    io_pulse,
  input logic                    pause,
  input logic                    carry_insert
);
  logic [7:0] plen;
  logic [1:0] ncarry;
  logic       armed;

  always_ff @(posedge clk) begin
    if (!rst_n)              plen <= '0;
    else if (!pause)         plen <= '0;
    else if (plen != 8'hFF)  plen <= plen + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         ncarry <= '0;
    else if (ts1 && fetch)              ncarry <= '0;
    else if (carry_insert && ncarry != 2'd3) ncarry <= ncarry + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             armed <= 1'b0;
    else if (ts1 && fetch)                  armed <= 1'b0;
    else if (io_pulse[0] && |skip_req)      armed <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!pause && io_pulse == '0 && !carry_insert));

  p_pause_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause) |-> $past(ts3 && fetch && instr[WORD_W-1 -: OPC_W] == OPC_IOT));

  p_pause_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause) |-> plen == 8'(NUM_SLOTS));

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_pulse));

  p_late_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_pulse[NUM_SLOTS-1]) |-> $past(pause));

  p_pulse_in_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_pulse != '0) |-> pause);

  p_carry_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    carry_insert |-> (ts4 && fetch && !pause));

  p_carry_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    carry_insert |-> ncarry == 2'd0);

  p_carry_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_insert |-> armed);
endmodule

bind iot_sequencer iot_sequencer_chk #(
  .WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .NUM_SKIP_SRC(NUM_SKIP_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .ts1(ts1), .ts3(ts3), .ts4(ts4),
  .fetch(fetch), .skip_req(skip_req), .io_pulse(io_pulse), .pause(pause),
  .carry_insert(carry_insert)
);

// File: tb/iot_sequencer_tb.sv
module iot_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] instr = '0;
  logic        ts1 = 1'b0, ts3 = 1'b0, ts4 = 1'b0, fetch = 1'b1;
  logic [2:0]  skip_req = '0;
  logic [2:0]  io_pulse;
  logic        pause, carry_insert;

  int checks = 0, failures = 0;
  int cyc = 0;
  logic [11:0] pc = '0;

  // observations from the last instruction
  int pulse_at [3];
  int pulse_cnt[3];
  int pause_cycles, carry_cnt, stray;

  always #10 clk = ~clk;

  iot_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .ts1(ts1), .ts3(ts3), .ts4(ts4),
    .fetch(fetch), .skip_req(skip_req), .io_pulse(io_pulse), .pause(pause),
    .carry_insert(carry_insert)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample_stray();
    #5;
    if (io_pulse != 3'b000 || carry_insert || pause) stray++;
  endtask

  // One instruction: TS1, TS2, TS3, pause slots, TS4. Inputs driven on falling edges.
  task automatic run_instr(input logic [11:0] w, input logic [2:0] sk, input logic fch);
    int slot;
    bit done;
    for (int k = 0; k < 3; k++) begin pulse_at[k] = -1; pulse_cnt[k] = 0; end
    pause_cycles = 0; carry_cnt = 0; stray = 0;
    @(negedge clk); instr = w; skip_req = sk; fetch = fch; ts1 = 1'b1;
    sample_stray();
    @(negedge clk); ts1 = 1'b0;
    sample_stray();
    @(negedge clk); ts3 = 1'b1;
    sample_stray();
    slot = 0; done = 1'b0;
    for (int g = 0; g < 12 && !done; g++) begin
      @(negedge clk); ts3 = 1'b0; ts4 = 1'b0;
      #5;
      if (pause) begin
        for (int k = 0; k < 3; k++)
          if (io_pulse[k]) begin pulse_cnt[k]++; pulse_at[k] = slot; end
        if (carry_insert) carry_cnt++;
        pause_cycles++;
        slot++;
      end else begin
        if (io_pulse != 3'b000) stray++;
        ts4 = 1'b1;
        #1;
        if (carry_insert) carry_cnt++;
        done = 1'b1;
      end
    end
    @(negedge clk); ts4 = 1'b0;
    #5; if (carry_insert) carry_cnt++;
    if (w[11:9] == 3'd5) pc = {5'd0, w[6:0]};
    else pc = pc + 12'd1 + 12'(carry_cnt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    check(pause == 1'b0, "R1 pause", pause, 0);
    check(io_pulse == 3'b000, "R1 io_pulse", io_pulse, 0);
    check(carry_insert == 1'b0, "R1 carry_insert", carry_insert, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_all_slots();
    run_instr(12'o6047, 3'b000, 1'b1);
    check(pause_cycles == 3, "R2 pause length 6047", pause_cycles, 3);
    check(pulse_at[0] == 0 && pulse_cnt[0] == 1, "R3 first pulse slot", pulse_at[0], 0);
    check(pulse_at[1] == 1 && pulse_cnt[1] == 1, "R3 second pulse slot", pulse_at[1], 1);
    check(pulse_at[2] == 2 && pulse_cnt[2] == 1, "R3 fourth pulse slot", pulse_at[2], 2);
    check(stray == 0, "R4 quiet outside pause", stray, 0);
  endtask

  task automatic t_no_bits();
    run_instr(12'o6040, 3'b100, 1'b1);
    check(pause_cycles == 3, "R2 pause length 6040", pause_cycles, 3);
    check(pulse_cnt[0] + pulse_cnt[1] + pulse_cnt[2] == 0, "R3 no pulse 6040",
          pulse_cnt[0] + pulse_cnt[1] + pulse_cnt[2], 0);
    check(carry_cnt == 0, "R6 no skip 6040", carry_cnt, 0);
  endtask

  task automatic t_write_char();
    logic [11:0] pc0;
    pc0 = pc;
    run_instr(12'o6046, 3'b111, 1'b1);
    check(pulse_cnt[0] == 0 && pulse_at[1] == 1 && pulse_at[2] == 2, "R3 6046 pulses",
          {pulse_cnt[0], pulse_at[1], pulse_at[2]}, 12);
    check(carry_cnt == 0, "R6 6046 ignores skip lines", carry_cnt, 0);
    check(pc - pc0 == 12'd1, "R6 6046 pc advance", pc - pc0, 1);
  endtask

  task automatic t_other_ops();
    run_instr(12'o7000, 3'b111, 1'b1);
    check(pause_cycles == 0 && stray == 0, "R4 opcode 7 no pause", pause_cycles, 0);
    check(carry_cnt == 0, "R4 opcode 7 no carry", carry_cnt, 0);
    run_instr(12'o6041, 3'b111, 1'b0);
    check(pause_cycles == 0 && stray == 0, "R4 non-fetch no pause", pause_cycles, 0);
    check(carry_cnt == 0, "R4 non-fetch no carry", carry_cnt, 0);
  endtask

  task automatic t_sources();
    for (int s = 0; s < 3; s++) begin
      run_instr(12'o6041, 3'(1 << s), 1'b1);
      check(carry_cnt == 1, $sformatf("R5 source %0d alone", s), carry_cnt, 1);
    end
  endtask

  task automatic t_loop();
    // loop: 0: 6041 (skip on teleprinter flag), 1: JMP 0, 2: JMP 0
    pc = 12'd0;
    run_instr(12'o6041, 3'b100, 1'b1);
    check(pc == 12'd2, "R7 skip taken advances by 2", pc, 2);
    check(carry_cnt == 1, "R7 single carry", carry_cnt, 1);
    run_instr(12'o5000, 3'b100, 1'b1);
    check(pc == 12'd0 && carry_cnt == 0, "R8 jump after skip no carry", carry_cnt, 0);
    run_instr(12'o6041, 3'b000, 1'b1);
    check(pc == 12'd1, "R7 flag clear advances by 1", pc, 1);
    run_instr(12'o5000, 3'b000, 1'b1);
    run_instr(12'o6041, 3'b100, 1'b1);
    check(pc == 12'd2, "R7 second pass advances by 2", pc, 2);
  endtask

  task automatic t_clear();
    run_instr(12'o6041, 3'b010, 1'b1);
    check(carry_cnt == 1, "R5 reader skip", carry_cnt, 1);
    run_instr(12'o6041, 3'b000, 1'b1);
    check(carry_cnt == 0, "R8 skip cleared at next fetch", carry_cnt, 0);
    run_instr(12'o7000, 3'b000, 1'b1);
    check(carry_cnt == 0, "R8 no carry into plain op", carry_cnt, 0);
  endtask

  initial begin
    t_reset();
    t_all_slots();
    t_no_bits();
    t_write_char();
    t_other_ops();
    t_sources();
    t_loop();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule